// File: doc/BRIEF.md
# Coin-Operated Vending Controller with Exact Change

This block is the sequencing core of a vending unit that sells one item priced at 25 cents. Each clock cycle it may be handed a single coin pulse: a nickel, a dime or a quarter. It keeps a running credit. When the credit reaches or passes the price, it raises its vend output for exactly one cycle. In that same cycle it raises the change outputs that pay back the amount above 25 cents. After that cycle it is back at zero credit, ready for the next customer.

The controller is a Moore machine, so all outputs depend only on the stored state. The state is a ten-bit one-hot vector. Five of its states hold credit (0, 5, 10, 15 and 20 cents). The other five are terminal states (25, 30, 35, 40 and 45 cents), and each lasts one cycle. A coin that lands in a credit state becomes visible at the outputs one cycle later. The coin source must make sure that each pulse lasts one cycle and that pulses do not overlap. A cycle in which two or more coin inputs are high is rejected as illegal.

Top module: `vend_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the controller at zero credit. In the cycle after a reset edge all four outputs are low, and a lone quarter presented next produces a vend with no change.
- R2: From a credit state, a lone nickel adds 5 cents, a lone dime adds 10 and a lone quarter adds 25. The new credit takes effect at the next clock edge.
- R3: In a credit state, a cycle with no coin input high leaves the credit unchanged.
- R4: The vend output is high exactly in the cycle after the edge that brought the credit to 25 cents or more. It is never high for two cycles in a row.
- R5: A terminal state always goes to zero credit at the next edge. Coin inputs presented during a terminal state are ignored and add nothing to the next purchase.
- R6: The change outputs depend on the terminal amount. At 25 cents none is raised. At 30 cents give_nickel is raised. At 35 cents give_dime is raised. At 40 cents give_dime and give_nickel are raised. At 45 cents only give_two_dimes is raised.
- R7: In a credit state, a cycle with two or more coin inputs high is illegal. The credit is left unchanged.
- R8: The state register always has exactly one of its ten bits set. A change output is never high without vend, and give_two_dimes is never high together with give_nickel or give_dime.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| rst | input | 1 | Synchronous active-high reset to zero credit |
| coin_nickel | input | 1 | One-cycle pulse: a 5-cent coin was accepted |
| coin_dime | input | 1 | One-cycle pulse: a 10-cent coin was accepted |
| coin_quarter | input | 1 | One-cycle pulse: a 25-cent coin was accepted |
| vend | output | 1 | Release the item (high in every terminal state) |
| give_nickel | output | 1 | Pay back one 5-cent coin |
| give_dime | output | 1 | Pay back one 10-cent coin |
| give_two_dimes | output | 1 | Pay back two 10-cent coins |

## Verification
The bench reaches each of the five terminal amounts on purpose, by ending on a quarter from every credit level and on a dime from 15 and 20 cents. A design with a wrong change map would pay out the wrong coins, and a design that added the wrong amount per coin would vend one cycle early or late. The bench sends coins while the machine is in a terminal state. A design that let those coins through would carry credit into the next purchase and vend too early. The bench also sends overlapping coin pulses. A design that accepted them, or that moved to zero credit on them, would vend at the wrong time. A reset in the middle of a purchase must discard the partial credit.

// File: rtl/vend_pkg.sv
package vend_pkg;
  // credit is counted in units of the smallest coin
  localparam int unsigned STEP_CENTS    = 5;
  localparam int unsigned PRICE_STEPS   = 5;
  localparam int unsigned NICKEL_STEPS  = 1;
  localparam int unsigned DIME_STEPS    = 2;
  localparam int unsigned QUARTER_STEPS = 5;
  localparam int unsigned MAX_STEPS     = QUARTER_STEPS;
  localparam int unsigned NUM_ST        = PRICE_STEPS + MAX_STEPS;
  localparam int unsigned STEP_W        = $clog2(MAX_STEPS + 1);

  typedef logic [NUM_ST-1:0] st_vec_t;

  typedef struct packed {
    logic vend;
    logic nickel;
    logic dime;
    logic two_dimes;
  } payout_t;

  // change for an overpay of 'excess' steps: {two_dimes, dime, nickel}
  function automatic logic [2:0] change_of(input int unsigned excess);
    logic [2:0] r;
    r = 3'b000;
    if (excess == 4) r[2] = 1'b1;
    else begin
      r[1] = (excess >= 2);
      r[0] = excess[0];
    end
    return r;
  endfunction

  function automatic int unsigned cents_of(input int unsigned idx);
    return idx * STEP_CENTS;
  endfunction
endpackage

// File: rtl/vend_coin_sel.sv
module vend_coin_sel
  import vend_pkg::*;
(
  input  logic              nickel_i,
  input  logic              dime_i,
  input  logic              quarter_i,
  output logic [STEP_W-1:0] steps_o,
  output logic              multi_o
);
  logic [1:0] n_hot;

  always_comb begin
    n_hot   = 2'(nickel_i) + 2'(dime_i) + 2'(quarter_i);
    multi_o = (n_hot > 2'd1);
    steps_o = '0;
    if (!multi_o) begin
      if (nickel_i)  steps_o = STEP_W'(NICKEL_STEPS);
      if (dime_i)    steps_o = STEP_W'(DIME_STEPS);
      if (quarter_i) steps_o = STEP_W'(QUARTER_STEPS);
    end
  end
endmodule

// File: rtl/vend_credit_next.sv
module vend_credit_next
  import vend_pkg::*;
(
  input  st_vec_t           cur_i,
  input  logic [STEP_W-1:0] steps_i,
  input  logic              multi_i,
  output st_vec_t           nxt_o,
  output logic              terminal_o
);
  always_comb begin
    terminal_o = |cur_i[NUM_ST-1:PRICE_STEPS];
    if (terminal_o) begin
      nxt_o    = '0;
      nxt_o[0] = 1'b1;
    end else if (multi_i || steps_i == '0) begin
      nxt_o = cur_i;
    end else begin
      // a credit index is at most PRICE_STEPS-1, so the shift stays in range
      nxt_o = cur_i << steps_i;
    end
  end
endmodule

// File: rtl/vend_change_dec.sv
module vend_change_dec
  import vend_pkg::*;
(
  input  st_vec_t cur_i,
  output payout_t pay_o
);
  logic [NUM_ST-1:0] hit_n, hit_d, hit_2d;

  for (genvar g = 0; g < NUM_ST; g++) begin : g_st
    if (g >= PRICE_STEPS) begin : g_term
      localparam logic [2:0] CHG = change_of(g - PRICE_STEPS);
      assign hit_2d[g] = cur_i[g] & CHG[2];
      assign hit_d[g]  = cur_i[g] & CHG[1];
      assign hit_n[g]  = cur_i[g] & CHG[0];
    end else begin : g_credit
      assign hit_2d[g] = 1'b0;
      assign hit_d[g]  = 1'b0;
      assign hit_n[g]  = 1'b0;
    end
  end

  assign pay_o.vend      = |cur_i[NUM_ST-1:PRICE_STEPS];
  assign pay_o.nickel    = |hit_n;
  assign pay_o.dime      = |hit_d;
  assign pay_o.two_dimes = |hit_2d;
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic coin_nickel,
  input  logic coin_dime,
  input  logic coin_quarter,
  output logic vend,
  output logic give_nickel,
  output logic give_dime,
  output logic give_two_dimes
);
  localparam st_vec_t ZERO_CREDIT = st_vec_t'(1);

  st_vec_t           state_q, state_d;
  logic [STEP_W-1:0] coin_steps;
  logic              coin_multi;
  logic              in_terminal;
  payout_t           pay;

  vend_coin_sel u_sel (
    .nickel_i (coin_nickel),
    .dime_i   (coin_dime),
    .quarter_i(coin_quarter),
    .steps_o  (coin_steps),
    .multi_o  (coin_multi)
  );

  vend_credit_next u_next (
    .cur_i     (state_q),
    .steps_i   (coin_steps),
    .multi_i   (coin_multi),
    .nxt_o     (state_d),
    .terminal_o(in_terminal)
  );

  vend_change_dec u_chg (
    .cur_i(state_q),
    .pay_o(pay)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= ZERO_CREDIT;
    else     state_q <= state_d;
  end

  assign vend           = pay.vend;
  assign give_nickel    = pay.nickel;
  assign give_dime      = pay.dime;
  assign give_two_dimes = pay.two_dimes;
endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk
  import vend_pkg::*;
(
  input logic    clk,
  input logic    rst,
  input st_vec_t state_q,
  input logic    coin_nickel,
  input logic    coin_dime,
  input logic    coin_quarter,
  input logic    coin_multi,
  input logic    in_terminal,
  input logic    vend,
  input logic    give_nickel,
  input logic    give_dime,
  input logic    give_two_dimes
);
  logic no_coin, nickel_only;
  assign no_coin     = !coin_nickel && !coin_dime && !coin_quarter;
  assign nickel_only = coin_nickel && !coin_dime && !coin_quarter;

  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> state_q == st_vec_t'(1)); // R1
  AST_NICKEL_ADDS: assert property (@(posedge clk) disable iff (rst)
    (!in_terminal && nickel_only) |=> state_q == ($past(state_q) << 1)); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!in_terminal && no_coin) |=> $stable(state_q)); // R3
  AST_VEND_SINGLE: assert property (@(posedge clk) disable iff (rst)
    vend |=> !vend); // R4
  AST_TERM_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    in_terminal |=> state_q[0]); // R5
  AST_CHANGE_45: assert property (@(posedge clk) disable iff (rst)
    state_q[NUM_ST-1] |-> (give_two_dimes && !give_dime && !give_nickel)); // R6
  AST_MULTI_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!in_terminal && coin_multi) |=> $stable(state_q)); // R7
  AST_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
    $countones(state_q) == 1); // R8
  AST_CHANGE_WITH_VEND: assert property (@(posedge clk) disable iff (rst)
    (give_nickel || give_dime || give_two_dimes) |-> vend); // R8
endmodule

bind vend_ctrl vend_ctrl_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .state_q       (state_q),
  .coin_nickel   (coin_nickel),
  .coin_dime     (coin_dime),
  .coin_quarter  (coin_quarter),
  .coin_multi    (coin_multi),
  .in_terminal   (in_terminal),
  .vend          (vend),
  .give_nickel   (give_nickel),
  .give_dime     (give_dime),
  .give_two_dimes(give_two_dimes)
);

// File: tb/vend_ctrl_test.sv
module vend_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cn = 1'b0, cd = 1'b0, cq = 1'b0;
  logic vend, gn, gd, g2;
  int   total = 0;
  int   bad = 0;
  int   model_c = 0;     // expected credit in cents after the last edge
  string cause = "R1";   // requirement behind the last transition

  always #4 clk = ~clk;  // 125 MHz

  vend_ctrl uut (
    .clk(clk), .rst(rst), .coin_nickel(cn), .coin_dime(cd), .coin_quarter(cq),
    .vend(vend), .give_nickel(gn), .give_dime(gd), .give_two_dimes(g2)
  );

  function automatic int next_credit(int c, logic r, logic n, logic d, logic q);
    int cnt = int'(n) + int'(d) + int'(q);
    if (r) return 0;
    if (c >= 25) return 0;
    if (cnt != 1) return c;
    return c + (n ? 5 : d ? 10 : 25);
  endfunction

  function automatic string cause_of(int c, logic r, logic n, logic d, logic q);
    int cnt = int'(n) + int'(d) + int'(q);
    if (r) return "R1";
    if (c >= 25) return "R5";
    if (cnt > 1) return "R7";
    if (cnt == 0) return "R3";
    return "R2";
  endfunction

  task automatic chk(string tag, logic act, logic exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b (credit %0d)", tag, what, act, exp, model_c);
    end
  endtask

  task automatic cyc(logic r, logic n, logic d, logic q);
    @(negedge clk);
    chk(cause, vend, model_c >= 25, "vend");
    chk("R6", gn, model_c == 30 || model_c == 40, "give_nickel");
    chk("R6", gd, model_c == 35 || model_c == 40, "give_dime");
    chk("R6", g2, model_c == 45, "give_two_dimes");
    chk("R8", (gn | gd | g2) & ~vend, 1'b0, "change without vend");
    chk("R8", g2 & (gn | gd), 1'b0, "two dimes mixed");
    rst = r; cn = n; cd = d; cq = q;
    cause   = cause_of(model_c, r, n, d, q);
    model_c = next_credit(model_c, r, n, d, q);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (2) @(posedge clk);
    // R1: reset state, then a lone quarter vends with no change
    cyc(1, 0, 0, 0);
    cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);
    // R2: five nickels reach 25
    repeat (5) cyc(0, 1, 0, 0);
    cyc(0, 0, 0, 0);
    // R6: quarter on top of 5,10,15,20 gives 30..45
    for (int k = 1; k <= 4; k++) begin
      repeat (k) cyc(0, 1, 0, 0);
      cyc(0, 0, 0, 1);
      cyc(0, 0, 0, 0);
      cyc(0, 0, 0, 0);
    end
    // R6: dime on 20 gives 30; dime on 15 gives 25
    cyc(0, 0, 1, 0); cyc(0, 0, 1, 0); cyc(0, 0, 1, 0); cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    cyc(0, 0, 1, 0); cyc(0, 1, 0, 0); cyc(0, 0, 1, 0); cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    // R7: overlapping pulses at 10 cents hold credit
    cyc(0, 0, 1, 0); cyc(0, 1, 1, 0); cyc(0, 1, 1, 1); cyc(0, 0, 1, 1);
    cyc(0, 0, 1, 0); cyc(0, 1, 0, 0); cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    // R5: coins during a terminal state are dropped
    cyc(0, 0, 0, 1); cyc(0, 0, 0, 0); cyc(0, 0, 0, 1); cyc(0, 0, 1, 0);
    cyc(0, 1, 0, 0); cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    // R1: reset in mid-purchase discards credit
    cyc(0, 0, 1, 0); cyc(0, 1, 0, 0); cyc(1, 0, 0, 0); cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int sel = int'($urandom % 20);
      logic n = 0, d = 0, q = 0, r = 0;
      if (sel < 3)       n = 1;
      else if (sel < 6)  d = 1;
      else if (sel < 8)  q = 1;
      else if (sel < 10) begin n = 1'($urandom); d = 1'($urandom); q = 1; end
      else if (sel == 10 && ($urandom % 8) == 0) r = 1;
      cyc(r, n, d, q);
    end
    cyc(0, 0, 0, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule